// File: doc/BRIEF.md
# Repeat-Instruction Sequencer with Operand Address Stepping

This block is the control unit that carries out a repeat meta-instruction. When it accepts a repeat command it captures a repetition count, a 2-bit stepping mode, a branch operand and the two operand addresses of the instruction that follows the repeat. It then issues that two-address instruction to an execute unit the requested number of times. Between issues it advances neither, one or both operand addresses by one, as the mode selects.

Each issue is a held request. The operand addresses stay presented until the execute unit answers with a one-cycle completion pulse, and only then do they step. When the last repetition completes, the sequencer does not fall through in line. It presents a fixed exit program-counter value with a one-cycle valid strobe, together with the captured branch operand that the unconditional branch stored at that exit location consumes. A count of zero skips issuing altogether and goes straight to the exit. A busy flag covers the whole operation, from acceptance up to and including the exit strobe.

Top module: `repeat_seq`

## Requirements
- R1: A command on `start_i` is accepted only in a cycle where `busy_o` is low. It captures `mode_i`, `count_i`, `w_i`, `u_i` and `v_i`, and `busy_o` is high from the next cycle on.
- R2: While `issue_valid_o` is high, `issue_u_o` and `issue_v_o` stay unchanged until a cycle in which `exec_done_i` is high. Each such cycle completes one repetition.
- R3: With mode 0 (`mode_i` = 2'b00), both operand addresses keep their captured values on every repetition.
- R4: With mode 1 (2'b01), the v address rises by one after each completed repetition and the u address stays fixed.
- R5: With mode 2 (2'b10), the u address rises by one after each completed repetition and the v address stays fixed.
- R6: With mode 3 (2'b11), both addresses rise by one after each completed repetition.
- R7: A command with count n ≥ 1 completes exactly n repetitions. The cycle after the n-th completion is the exit cycle, and `issue_valid_o` is then low.
- R8: A count of zero produces no issue. The exit cycle follows immediately after the cycle of acceptance.
- R9: In the exit cycle, `exit_valid_o` is high for that one cycle only, `exit_pc_o` equals the parameter EXIT_PC, and `exit_w_o` equals the captured w. `busy_o` is high in the exit cycle and low in the cycle after it.
- R10: A `start_i` seen while `busy_o` is high has no effect, and that includes the exit cycle. An `exec_done_i` seen while `issue_valid_o` is low also has no effect.
- R11: Address stepping wraps modulo 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Repeat command request |
| mode_i | input | 2 | Stepping mode: bit 1 steps u, bit 0 steps v |
| count_i | input | CNT_W | Number of repetitions |
| w_i | input | W_W | Branch operand handed on at exit |
| u_i | input | ADDR_W | First operand address of the repeated instruction |
| v_i | input | ADDR_W | Second operand address of the repeated instruction |
| issue_valid_o | output | 1 | Repeated instruction presented to the execute unit |
| issue_u_o | output | ADDR_W | Current first operand address |
| issue_v_o | output | ADDR_W | Current second operand address |
| exec_done_i | input | 1 | Execute unit completion pulse |
| exit_valid_o | output | 1 | One-cycle strobe for the exit redirect |
| exit_pc_o | output | PC_W | Fixed exit program-counter value |
| exit_w_o | output | W_W | Captured branch operand |
| busy_o | output | 1 | Operation in progress |

## Verification
Two events can land in the same cycle: a new command on `start_i`, and the final exit strobe of the running operation, in which `busy_o` is still high. The bench drives `start_i` with a zero count exactly in the exit cycle. It then judges the following cycle: `busy_o` and `exit_valid_o` must both be low, because a command that had been wrongly accepted would show a second exit strobe there. In the same spirit, commands raised in the middle of issuing are checked against the held addresses and the final w, and completion pulses raised while idle are checked against the outputs staying quiet.

// File: rtl/rs_pkg.sv
package rs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_EXIT  = 2'd2
    } rs_state_e;

    // mode bit 1 advances the first operand, bit 0 the second
    function automatic logic steps_u(input logic [1:0] mode);
        return mode[1];
    endfunction

    function automatic logic steps_v(input logic [1:0] mode);
        return mode[0];
    endfunction
endpackage

// File: rtl/rs_count_dec.sv
module rs_count_dec #(
    parameter int CNT_W = 8
) (
    input  logic [CNT_W-1:0] cnt_i,
    output logic [CNT_W-1:0] dec_o,
    output logic             last_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_comb begin
        dec_o  = cnt_i - ONE;
        last_o = (cnt_i == ONE);
    end
endmodule

// File: rtl/rs_addr_step.sv
module rs_addr_step #(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              en_i,
    output logic [ADDR_W-1:0] addr_o
);
    always_comb begin
        addr_o = addr_i + ADDR_W'(en_i);
    end
endmodule

// File: rtl/repeat_seq.sv
module repeat_seq
    import rs_pkg::*;
#(
    parameter int          ADDR_W  = 12,
    parameter int          CNT_W   = 8,
    parameter int          W_W     = 12,
    parameter int          PC_W    = 12,
    parameter logic [11:0] EXIT_PC = 12'h040
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        mode_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic [W_W-1:0]    w_i,
    input  logic [ADDR_W-1:0] u_i,
    input  logic [ADDR_W-1:0] v_i,
    output logic              issue_valid_o,
    output logic [ADDR_W-1:0] issue_u_o,
    output logic [ADDR_W-1:0] issue_v_o,
    input  logic              exec_done_i,
    output logic              exit_valid_o,
    output logic [PC_W-1:0]   exit_pc_o,
    output logic [W_W-1:0]    exit_w_o,
    output logic              busy_o
);
    localparam int NOPS = 2;

    typedef struct packed {
        rs_state_e         st;
        logic [CNT_W-1:0]  left;
        logic [ADDR_W-1:0] u;
        logic [ADDR_W-1:0] v;
        logic [1:0]        mode;
        logic [W_W-1:0]    w;
    } regs_t;

    regs_t q, d;

    logic [CNT_W-1:0]  left_dec;
    logic              left_last;
    logic [ADDR_W-1:0] cur_a [NOPS];
    logic [ADDR_W-1:0] nxt_a [NOPS];
    logic              en_a  [NOPS];

    rs_count_dec #(.CNT_W(CNT_W)) u_cnt (
        .cnt_i  (q.left),
        .dec_o  (left_dec),
        .last_o (left_last)
    );

    always_comb begin
        cur_a[0] = q.u;
        cur_a[1] = q.v;
        en_a[0]  = steps_u(q.mode);
        en_a[1]  = steps_v(q.mode);
    end

    for (genvar g = 0; g < NOPS; g++) begin : g_step
        rs_addr_step #(.ADDR_W(ADDR_W)) u_step (
            .addr_i (cur_a[g]),
            .en_i   (en_a[g]),
            .addr_o (nxt_a[g])
        );
    end

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.mode = mode_i;
                    d.left = count_i;
                    d.w    = w_i;
                    d.u    = u_i;
                    d.v    = v_i;
                    d.st   = (count_i == '0) ? ST_EXIT : ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                if (exec_done_i) begin
                    d.u    = nxt_a[0];
                    d.v    = nxt_a[1];
                    d.left = left_dec;
                    d.st   = left_last ? ST_EXIT : ST_ISSUE;
                end
            end
            ST_EXIT: begin
                d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, left: '0, u: '0, v: '0, mode: 2'b00, w: '0};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        issue_valid_o = (q.st == ST_ISSUE);
        issue_u_o     = q.u;
        issue_v_o     = q.v;
        exit_valid_o  = (q.st == ST_EXIT);
        exit_pc_o     = PC_W'(EXIT_PC);
        exit_w_o      = q.w;
        busy_o        = (q.st != ST_IDLE);
    end
endmodule

// File: rtl/rs_checker.sv
module rs_checker #(
    parameter int ADDR_W = 12,
    parameter int CNT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [CNT_W-1:0]  count_i,
    input logic              issue_valid_o,
    input logic [ADDR_W-1:0] issue_u_o,
    input logic [ADDR_W-1:0] issue_v_o,
    input logic              exec_done_i,
    input logic              exit_valid_o,
    input logic              busy_o
);
    logic [CNT_W-1:0] want_q;
    logic [CNT_W-1:0] seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            want_q <= '0;
            seen_q <= '0;
        end else if (start_i && !busy_o) begin
            want_q <= count_i;
            seen_q <= '0;
        end else if (issue_valid_o && exec_done_i) begin
            seen_q <= seen_q + CNT_W'(1);
        end
    end

    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid_o && !exec_done_i) |=>
            (issue_valid_o && $stable(issue_u_o) && $stable(issue_v_o)));

    // R3 to R6: any change between repetitions is a single unit step
    a_r6_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid_o && exec_done_i) |=>
            (!issue_valid_o ||
             ((issue_u_o == $past(issue_u_o) || issue_u_o == $past(issue_u_o) + ADDR_W'(1)) &&
              (issue_v_o == $past(issue_v_o) || issue_v_o == $past(issue_v_o) + ADDR_W'(1)))));

    a_r7_exact_count: assert property (@(posedge clk) disable iff (!rst_n)
        exit_valid_o |-> (seen_q == want_q));

    a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(issue_valid_o && exit_valid_o));

    a_r8_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && count_i == '0) |=> exit_valid_o);

    a_r9_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        exit_valid_o |=> (!exit_valid_o && !busy_o));

    a_r1_busy_cover: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid_o || exit_valid_o) |-> busy_o);

    a_r1_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);
endmodule

bind repeat_seq rs_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .count_i       (count_i),
    .issue_valid_o (issue_valid_o),
    .issue_u_o     (issue_u_o),
    .issue_v_o     (issue_v_o),
    .exec_done_i   (exec_done_i),
    .exit_valid_o  (exit_valid_o),
    .busy_o        (busy_o)
);

// File: tb/repeat_seq_tb.sv
module repeat_seq_tb;
    localparam int          CLK_PERIOD = 10;
    localparam int          ADDR_W     = 12;
    localparam int          CNT_W      = 8;
    localparam int          W_W        = 12;
    localparam int          PC_W       = 12;
    localparam logic [11:0] EXIT_PC    = 12'h040;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [1:0]        mode_i = 2'b00;
    logic [CNT_W-1:0]  count_i = '0;
    logic [W_W-1:0]    w_i = '0;
    logic [ADDR_W-1:0] u_i = '0;
    logic [ADDR_W-1:0] v_i = '0;
    logic              issue_valid_o;
    logic [ADDR_W-1:0] issue_u_o;
    logic [ADDR_W-1:0] issue_v_o;
    logic              exec_done_i = 1'b0;
    logic              exit_valid_o;
    logic [PC_W-1:0]   exit_pc_o;
    logic [W_W-1:0]    exit_w_o;
    logic              busy_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    repeat_seq #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .W_W(W_W), .PC_W(PC_W), .EXIT_PC(EXIT_PC)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .count_i(count_i), .w_i(w_i), .u_i(u_i), .v_i(v_i),
        .issue_valid_o(issue_valid_o), .issue_u_o(issue_u_o), .issue_v_o(issue_v_o),
        .exec_done_i(exec_done_i), .exit_valid_o(exit_valid_o), .exit_pc_o(exit_pc_o),
        .exit_w_o(exit_w_o), .busy_o(busy_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // run one repeat command; done_gap idle cycles before each completion pulse;
    // late_start drives a zero-count command in the exit cycle
    task automatic run_repeat(input string req, input logic [1:0] mode, input int n,
                              input logic [ADDR_W-1:0] u0, input logic [ADDR_W-1:0] v0,
                              input logic [W_W-1:0] w, input int done_gap,
                              input bit late_start, input bit mid_start);
        logic [ADDR_W-1:0] eu, ev;
        eu = u0;
        ev = v0;
        @(negedge clk);
        start_i = 1'b1; mode_i = mode; count_i = CNT_W'(n); w_i = w; u_i = u0; v_i = v0;
        @(negedge clk);
        start_i = 1'b0;
        check({req, " R1 busy"}, 32'(busy_o), 32'd1);
        for (int k = 0; k < n; k++) begin
            check({req, " R7 issue valid"}, 32'(issue_valid_o), 32'd1);
            check({req, " u addr"}, 32'(issue_u_o), 32'(eu));
            check({req, " v addr"}, 32'(issue_v_o), 32'(ev));
            for (int g = 0; g < done_gap; g++) begin
                if (mid_start && g == 0) begin
                    start_i = 1'b1; mode_i = ~mode; count_i = 8'd0;
                    w_i = ~w; u_i = ~u0; v_i = ~v0;
                end
                @(negedge clk);
                start_i = 1'b0;
                check({req, " R2/R10 held u"}, 32'(issue_u_o), 32'(eu));
                check({req, " R2/R10 held v"}, 32'(issue_v_o), 32'(ev));
                check({req, " R2 still valid"}, 32'(issue_valid_o), 32'd1);
            end
            exec_done_i = 1'b1;
            @(negedge clk);
            exec_done_i = 1'b0;
            eu = eu + ADDR_W'(mode[1]);
            ev = ev + ADDR_W'(mode[0]);
        end
        check({req, " R7/R8 exit strobe"}, 32'(exit_valid_o), 32'd1);
        check({req, " R7 no issue at exit"}, 32'(issue_valid_o), 32'd0);
        check({req, " R9 exit pc"}, 32'(exit_pc_o), 32'(EXIT_PC));
        check({req, " R9 exit w"}, 32'(exit_w_o), 32'(w));
        check({req, " R9 busy in exit"}, 32'(busy_o), 32'd1);
        if (late_start) begin
            start_i = 1'b1; count_i = 8'd0; mode_i = 2'b00;
        end
        @(negedge clk);
        start_i = 1'b0;
        check({req, " R9/R10 busy after"}, 32'(busy_o), 32'd0);
        check({req, " R9 strobe one cycle"}, 32'(exit_valid_o), 32'd0);
    endtask

    task automatic t_reset();
        check("R1 reset busy", 32'(busy_o), 32'd0);
        check("R7 reset issue", 32'(issue_valid_o), 32'd0);
        check("R9 reset exit", 32'(exit_valid_o), 32'd0);
    endtask

    task automatic t_idle_done();
        @(negedge clk);
        exec_done_i = 1'b1;
        @(negedge clk);
        exec_done_i = 1'b0;
        check("R10 done idle busy", 32'(busy_o), 32'd0);
        check("R10 done idle issue", 32'(issue_valid_o), 32'd0);
        check("R10 done idle exit", 32'(exit_valid_o), 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        run_repeat("R3 mode0",       2'b00, 3, 12'h100, 12'h200, 12'h0A5, 0, 1'b0, 1'b0);
        run_repeat("R4 mode1",       2'b01, 4, 12'h010, 12'h020, 12'h123, 1, 1'b0, 1'b0);
        run_repeat("R5 mode2",       2'b10, 4, 12'h300, 12'h400, 12'h456, 2, 1'b0, 1'b0);
        run_repeat("R6 mode3",       2'b11, 5, 12'h050, 12'h060, 12'h789, 0, 1'b0, 1'b0);
        run_repeat("R8 zero count",  2'b11, 0, 12'h111, 12'h222, 12'hABC, 0, 1'b0, 1'b0);
        run_repeat("R11 wrap",       2'b11, 3, 12'hFFE, 12'hFFF, 12'h001, 0, 1'b0, 1'b0);
        run_repeat("R10 late start", 2'b01, 2, 12'h070, 12'h080, 12'h0F0, 0, 1'b1, 1'b0);
        run_repeat("R10 mid start",  2'b10, 3, 12'h090, 12'h0A0, 12'h5A5, 2, 1'b0, 1'b1);
        run_repeat("R7 single",      2'b11, 1, 12'h000, 12'h000, 12'h3C3, 3, 1'b0, 1'b0);
        t_idle_done();
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule